// File: doc/BRIEF.md
# MDIO Station Management Master

This block is the management-controller end of a two-wire PHY management link. It divides the system clock into the management clock MDC. It also serializes one read or one write frame at a time onto MDIO. The host supplies a start pulse, a read/write select, a PHY address, a register address and write data. The block reports `busy` while a frame is in flight, then returns the read data together with a single-cycle `done` pulse.

Every frame ends with one released idle bit. After reset, the first frame always carries a preamble of 32 ones. The block also keeps a record of whether the PHY has reported that it accepts frames without a preamble. It sets that record from bit 6 of any completed read of register address 1. When the host allows skipping and that record is set, later frames start directly with the start pattern. The external pull-up is modelled by treating a released line as 1.

Top module: `mdio_master`

## Requirements
- R1: While busy, MDC is low for HALF_DIV clocks and then high for HALF_DIV clocks in every bit. While idle, MDC is held low.
- R2: The first frame after reset is preceded by 32 MDC periods with MDIO driven to 1.
- R3: The driven frame bits go out MSB first in this order: start `01`, opcode (`10` = read, `01` = write), 5-bit PHY address, 5-bit register address. The frame then continues with a 2-bit turnaround and 16 data bits, so it is 32 bits long without preamble.
- R4: On a read, the block releases MDIO (`mdio_oe`=0) for the turnaround and all 16 data bits. It samples `mdio_i` on MDC rising edges and returns the data MSB first on `rd_data` when `done` pulses.
- R5: On a write, the block drives the turnaround as `10`, followed by `wr_data` MSB first.
- R6: A completed read of register address 1 stores bit 6 of the returned data as the skip capability. Reads of other addresses leave it unchanged. A later frame omits the preamble only when `supp_allow`=1, the capability is 1 and a preamble has been sent since reset. Otherwise it sends the 32-bit preamble.
- R7: Each frame ends with one full MDC period with MDIO released. This idle bit is bit 33 without preamble and bit 65 with preamble.
- R8: While it drives MDIO, the block changes `mdio_o` only in the clock where MDC falls.
- R9: A start pulse that arrives while busy is ignored. The running frame is unaffected and no extra frame follows.
- R10: `done` is high for exactly one clock, in the clock that follows the end of the idle bit. `busy` falls in that same clock, so busy lasts (bits × 2 × HALF_DIV) clocks.
- R11: Reset returns the block to idle, with MDC low, MDIO released, `done` low and the skip capability and preamble history cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame (accepted only when idle) |
| rd_req | input | 1 | 1 = read frame, 0 = write frame |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data for write frames |
| supp_allow | input | 1 | Permit preamble skipping when the PHY supports it |
| mdio_i | input | 1 | Sampled MDIO line level |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Data from the last read frame |

## Verification
The bench builds the block with HALF_DIV=2, so each MDC bit is four system clocks. This keeps full 65-bit frames short enough to run a long sequence of transactions back to back. The divider is still wide enough to separate the falling edge, the sampling point and the rising edge into different clocks. The bench runs a behavioural PHY on the line that returns chosen words. This setup puts within reach the sequences that set and clear the skip capability, the reads of other registers that must leave it alone, and the 31/31 address corners.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF_DIV = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rd_req,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  input  logic        supp_allow,
  input  logic        mdio_i,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data
);
  localparam int DW = (2 * HALF_DIV > 2) ? $clog2(2 * HALF_DIV) : 1;
  localparam logic [DW-1:0] D_LAST = DW'(2 * HALF_DIV - 1);
  localparam logic [DW-1:0] D_HIGH = DW'(HALF_DIV);
  localparam logic [DW-1:0] D_SAMP = DW'(HALF_DIV - 1);
  localparam logic [4:0] STATUS_ADDR = 5'd1;
  localparam int SKIP_BIT = 6;

  logic [DW-1:0] div_cnt;
  logic [6:0]    bit_cnt;
  logic [31:0]   frame;
  logic [15:0]   rx_sh;
  logic          is_rd, to_status, pre_sent, can_skip;

  wire in_pre   = bit_cnt < 7'd32;
  wire in_idle  = bit_cnt == 7'd64;
  wire [4:0] fpos = bit_cnt[4:0];
  wire bit_end  = busy && div_cnt == D_LAST;
  wire sample   = busy && div_cnt == D_SAMP;
  wire skip_pre = pre_sent && supp_allow && can_skip;

  assign mdc     = busy && div_cnt >= D_HIGH;
  assign mdio_o  = (!busy || in_pre || in_idle) ? 1'b1 : frame[5'd31 - fpos];
  assign mdio_oe = busy && !in_idle && !(is_rd && !in_pre && fpos >= 5'd14);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt   <= '0;
      bit_cnt   <= '0;
      frame     <= '0;
      rx_sh     <= '0;
      is_rd     <= 1'b0;
      to_status <= 1'b0;
      pre_sent  <= 1'b0;
      can_skip  <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      rd_data   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy      <= 1'b1;
          div_cnt   <= '0;
          is_rd     <= rd_req;
          to_status <= reg_addr == STATUS_ADDR;
          frame     <= {2'b01, rd_req ? 2'b10 : 2'b01, phy_addr, reg_addr, 2'b10, wr_data};
          bit_cnt   <= skip_pre ? 7'd32 : 7'd0;
        end
      end else begin
        div_cnt <= bit_end ? '0 : div_cnt + 1'b1;
        if (sample && is_rd && !in_pre && !in_idle && fpos >= 5'd16)
          rx_sh <= {rx_sh[14:0], mdio_i};
        if (bit_end) begin
          if (in_idle) begin
            busy     <= 1'b0;
            done     <= 1'b1;
            pre_sent <= 1'b1;
            if (is_rd) begin
              rd_data <= rx_sh;
              if (to_status) can_skip <= rx_sh[SKIP_BIT];
            end
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic busy,
  input logic done
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));                                          // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                        // R10
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);                                                  // R10
  AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && mdio_oe && $past(mdio_oe) && !$fell(mdc)) |-> $stable(mdio_o)); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> (busy || done));                           // R9
  AST_RELEASE_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!mdio_oe));                                              // R7
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .busy(busy), .done(done)
);

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
  localparam int HD = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rd_req = 1'b0, supp_allow = 1'b0;
  logic [4:0] phy_addr = '0, reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic mdc, mdio_o, mdio_oe, busy, done, mdio_i;
  logic [15:0] rd_data;

  int errors = 0, checks = 0;

  logic phy_drv = 1'b0, phy_val = 1'b1;
  logic cur_rd = 1'b0;
  int   cur_off = 0;
  logic [15:0] cur_resp = '0;
  int   edges = 0, cap_n = 0;
  logic [63:0] cap = '0;
  logic last_oe = 1'b0;

  always #2.5 clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

  mdio_master #(.HALF_DIV(HD)) u_mdio_master (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .phy_addr(phy_addr),
    .reg_addr(reg_addr), .wr_data(wr_data), .supp_allow(supp_allow), .mdio_i(mdio_i),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy), .done(done), .rd_data(rd_data)
  );

  always @(posedge mdc) begin
    edges = edges + 1;
    last_oe = mdio_oe;
    if (mdio_oe) begin
      cap = {cap[62:0], mdio_o};
      cap_n = cap_n + 1;
    end
  end

  always @(negedge mdc) begin
    int np;
    np = edges - cur_off;
    phy_drv = 1'b0;
    phy_val = 1'b1;
    if (cur_rd && np == 15) begin phy_drv = 1'b1; phy_val = 1'b0; end
    if (cur_rd && np >= 16 && np <= 31) begin
      phy_drv = 1'b1;
      phy_val = cur_resp[31 - np];
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_txn(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] dat, input logic sa, input logic pre,
                         input bit poke);
    int busy_cyc, done_cnt, viol, it;
    bit seen;
    logic p_mdc, p_o, p_oe, p_busy;
    logic [63:0] exp_bits;
    int exp_n, exp_edges;
    @(negedge clk);
    cur_rd = rd; cur_off = pre ? 32 : 0; cur_resp = dat;
    edges = 0; cap = '0; cap_n = 0; last_oe = 1'b1;
    rd_req = rd; phy_addr = pa; reg_addr = ra; wr_data = dat; supp_allow = sa;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy_cyc = 0; done_cnt = 0; viol = 0; seen = 0; it = 0;
    p_mdc = mdc; p_o = mdio_o; p_oe = mdio_oe; p_busy = 1'b0;
    while (it < 2000) begin
      if (busy) busy_cyc++;
      if (done) begin done_cnt++; seen = 1; end
      if (p_busy && busy && p_oe && mdio_oe && mdio_o != p_o && !(p_mdc && !mdc)) viol++;
      p_mdc = mdc; p_o = mdio_o; p_oe = mdio_oe; p_busy = busy;
      if (poke && it == 10) begin
        start = 1'b1; rd_req = ~rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~dat;
      end
      if (poke && it == 11) start = 1'b0;
      if (seen && it > 0) break;
      @(negedge clk);
      it++;
    end
    if (!seen) check(0, "R10", "watchdog: done never seen", 0, 1);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (done) done_cnt++;
      if (busy) busy_cyc = busy_cyc + 1000;
    end
    exp_edges = (pre ? 32 : 0) + 33;
    if (rd) begin
      exp_bits = {50'h0, 2'b01, 2'b10, pa, ra};
      exp_n = 14;
    end else begin
      exp_bits = {32'h0, 2'b01, 2'b01, pa, ra, 2'b10, dat};
      exp_n = 32;
    end
    if (pre) begin
      exp_bits = exp_bits | ({32'h0, 32'hFFFF_FFFF} << exp_n);
      exp_n = exp_n + 32;
    end
    check(edges == exp_edges, pre ? "R2" : "R6", "MDC periods", edges, exp_edges);
    check(busy_cyc == exp_edges * 2 * HD, "R1", "busy clocks", busy_cyc, exp_edges * 2 * HD);
    check(cap_n == exp_n, rd ? "R4" : "R5", "driven bit count", cap_n, exp_n);
    check(cap == exp_bits, rd ? "R3" : "R5", "driven bits", cap, exp_bits);
    check(last_oe == 1'b0, "R7", "idle bit released", last_oe, 0);
    check(done_cnt == 1, poke ? "R9" : "R10", "done pulses", done_cnt, 1);
    check(viol == 0, "R8", "MDIO changed off MDC fall", viol, 0);
    if (rd) check(rd_data == dat, "R4", "read data", rd_data, dat);
    cur_rd = 1'b0;
  endtask

  // {rd, phy, reg, data, supp_allow, expect_preamble}
  localparam int NV = 10;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 5'd3,  5'd1,  16'h7849, 1'b1, 1'b1},
    {1'b0, 5'd3,  5'd0,  16'h1234, 1'b1, 1'b0},
    {1'b1, 5'd3,  5'd2,  16'hA5C3, 1'b0, 1'b1},
    {1'b1, 5'd3,  5'd1,  16'h0000, 1'b1, 1'b0},
    {1'b0, 5'd3,  5'd4,  16'hBEEF, 1'b1, 1'b1},
    {1'b1, 5'd3,  5'd5,  16'h0040, 1'b1, 1'b1},
    {1'b0, 5'd31, 5'd31, 16'h8001, 1'b1, 1'b1},
    {1'b1, 5'd0,  5'd1,  16'hFFFF, 1'b1, 1'b1},
    {1'b0, 5'd31, 5'd31, 16'h5555, 1'b1, 1'b0},
    {1'b1, 5'd17, 5'd10, 16'hC0DE, 1'b1, 1'b0}
  };

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !mdc && !mdio_oe, "R11", "reset idle state",
          {busy, done, mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!mdc && !mdio_oe, "R1", "MDC low while idle", {mdc, mdio_oe}, 0);

    for (int i = 0; i < NV; i++)
      run_txn(VEC[i][28], VEC[i][27:23], VEC[i][22:18], VEC[i][17:2], VEC[i][1], VEC[i][0], 0);

    // start pulses while busy are ignored (R9); skip still active here
    run_txn(1'b0, 5'd9, 5'd3, 16'h0F0F, 1'b1, 1'b0, 1);

    // reset clears the skip state and preamble history (R11)
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy && !mdc && !mdio_oe, "R11", "idle after mid-run reset", {busy, mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    run_txn(1'b0, 5'd3, 5'd0, 16'h2468, 1'b1, 1'b1, 0);
    run_txn(1'b1, 5'd3, 5'd1, 16'h0040, 1'b1, 1'b1, 0);
    run_txn(1'b0, 5'd3, 5'd0, 16'h1357, 1'b1, 1'b0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule